// File: doc/BRIEF.md
# Accumulator Instruction-Cycle Processor Core

This block is a compact single-accumulator processor. It runs a strict, non-overlapped instruction cycle: a fetch, a decode, an execute sequence and an interrupt check. Every word that moves between the core and memory passes through an explicit address latch and data buffer register, one transfer per phase. The core drives a synchronous single-port memory. Read data is returned one clock after the address is presented, so each read phase is followed by a wait state.

Instructions are 16 bits wide. The opcode sits in bits 15:12 and a 12-bit word address in bits 11:0. The core offers loads, stores, five ALU operations, a jump, a return from interrupt and a halt. A single level-sensitive interrupt request is honoured only between instructions, and only while interrupts are enabled. Taking it saves the program counter in a shadow register and redirects the next fetch to a fixed handler address.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, and on leaving it, pc_value is 0, acc_value is 0, halted is 0, illegal is 0 and int_en is 1. The first fetch reads address 0.
- R2: Each instruction word is fetched from the address in the program counter. The program counter then advances by one, so a program runs in sequence from address 0.
- R3: A memory read presents its address on mem_addr and captures mem_rdata on the following clock. A memory write asserts mem_we for one cycle, with the target address on mem_addr and the data on mem_wdata.
- R4: Opcodes 1 (load), 3 (add), 4 (subtract), 5 (AND) and 6 (OR) read the word at the address field and combine it with the accumulator. The result is written to the accumulator, and arithmetic wraps modulo 2^16. Opcode 7 inverts the accumulator and ignores the address field.
- R5: Opcode 2 (store) writes the accumulator to the word at the address field.
- R6: Opcode 8 (jump) loads the program counter with the address field. The next fetch comes from that address.
- R7: Opcode 0 (halt) stops the core with halted at 1 until the next reset. While halted, the core performs no memory writes, leaves the program counter unchanged and ignores irq. The program counter then holds the halt's address plus one.
- R8: Opcodes 10 to 15 set illegal to 1 and halt the core, with no execute sequence.
- R9: irq is sampled only after an instruction's execute sequence has finished. If irq is 1 and int_en is 1, the core saves the program counter (already advanced) in a shadow register and clears int_en. The next fetch then comes from address 0x010.
- R10: While int_en is 0, a held irq does not start another interrupt entry.
- R11: Opcode 9 (return from interrupt) restores the program counter from the shadow register and sets int_en to 1. The interrupted program resumes at the instruction after the one that completed before entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| mem_addr | output | 12 | Memory address, driven from the address latch |
| mem_wdata | output | 16 | Memory write data, driven from the data buffer |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | An undefined opcode was decoded |
| int_en | output | 1 | Interrupts currently enabled |
| acc_value | output | 16 | Accumulator contents |
| pc_value | output | 12 | Program counter contents |

## Verification
The hardest situation to reach is a correct round trip through the interrupt path. The request has to be held through an entire handler without a second entry. The return has to land exactly on the instruction after the one that completed. The stimulus raises irq before reset is released and holds it until the handler's store appears on the memory port. The return point is then shown by a sum that can come out right only if the interrupted add resumed with the handler's loaded value. A separate check raises irq after a halt and watches the program counter and the write strobe.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_NOT   = 4'd7,
    OP_JUMP  = 4'd8,
    OP_RETI  = 4'd9
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_NOT
  } alu_op_e;

  typedef enum logic [3:0] {
    PH_FADDR,   // address latch <- program counter
    PH_FWAIT,   // memory read wait state
    PH_FCAP,    // buffer <- read data
    PH_FIR,     // instruction register <- buffer, pc advance
    PH_DEC,     // decode
    PH_EADDR,   // address latch <- operand address
    PH_EWAIT,   // operand read wait state
    PH_ECAP,    // buffer <- operand
    PH_EALU,    // accumulator <- ALU result
    PH_SPREP,   // buffer <- accumulator
    PH_SWR,     // memory write
    PH_ICHK,    // interrupt check
    PH_INT,     // interrupt entry
    PH_HALT     // stopped
  } phase_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mbr_from_mem;
    logic    mbr_from_acc;
    logic    ir_load;
    logic    pc_inc;
    logic    pc_jump;
    logic    pc_reti;
    logic    acc_load;
    alu_op_e alu_op;
    logic    mem_we;
    logic    int_take;
    logic    flag_illegal;
  } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  alu_op_e             op,
  input  logic [WORD_W-1:0]   acc_in,
  input  logic [WORD_W-1:0]   opnd_in,
  output logic [WORD_W-1:0]   result
);

  always_comb begin
    unique case (op)
      ALU_PASS: result = opnd_in;
      ALU_ADD:  result = acc_in + opnd_in;
      ALU_SUB:  result = acc_in - opnd_in;
      ALU_AND:  result = acc_in & opnd_in;
      ALU_OR:   result = acc_in | opnd_in;
      ALU_NOT:  result = ~acc_in;
      default:  result = opnd_in;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_core_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e opcode,
  input  logic    irq,
  input  logic    int_en,
  output phase_e  phase,
  output ctrl_t   ctl
);

  phase_e  phase_q, phase_d;
  alu_op_e alu_sel;

  // ALU function chosen by the instruction register opcode
  always_comb begin
    unique case (opcode)
      OP_ADD:  alu_sel = ALU_ADD;
      OP_SUB:  alu_sel = ALU_SUB;
      OP_AND:  alu_sel = ALU_AND;
      OP_OR:   alu_sel = ALU_OR;
      OP_NOT:  alu_sel = ALU_NOT;
      default: alu_sel = ALU_PASS;
    endcase
  end

  always_comb begin
    phase_d    = phase_q;
    ctl        = '0;
    ctl.alu_op = ALU_PASS;
    unique case (phase_q)
      PH_FADDR: begin
        ctl.mar_from_pc = 1'b1;
        phase_d         = PH_FWAIT;
      end
      PH_FWAIT: phase_d = PH_FCAP;
      PH_FCAP: begin
        ctl.mbr_from_mem = 1'b1;
        phase_d          = PH_FIR;
      end
      PH_FIR: begin
        ctl.ir_load = 1'b1;
        ctl.pc_inc  = 1'b1;
        phase_d     = PH_DEC;
      end
      PH_DEC: begin
        unique case (opcode)
          OP_HALT: phase_d = PH_HALT;
          OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_AND, OP_OR:
            phase_d = PH_EADDR;
          OP_NOT: phase_d = PH_EALU;
          OP_JUMP: begin
            ctl.pc_jump = 1'b1;
            phase_d     = PH_ICHK;
          end
          OP_RETI: begin
            ctl.pc_reti = 1'b1;
            phase_d     = PH_ICHK;
          end
          default: begin
            ctl.flag_illegal = 1'b1;
            phase_d          = PH_HALT;
          end
        endcase
      end
      PH_EADDR: begin
        ctl.mar_from_ir = 1'b1;
        phase_d         = (opcode == OP_STORE) ? PH_SPREP : PH_EWAIT;
      end
      PH_EWAIT: phase_d = PH_ECAP;
      PH_ECAP: begin
        ctl.mbr_from_mem = 1'b1;
        phase_d          = PH_EALU;
      end
      PH_EALU: begin
        ctl.acc_load = 1'b1;
        ctl.alu_op   = alu_sel;
        phase_d      = PH_ICHK;
      end
      PH_SPREP: begin
        ctl.mbr_from_acc = 1'b1;
        phase_d          = PH_SWR;
      end
      PH_SWR: begin
        ctl.mem_we = 1'b1;
        phase_d    = PH_ICHK;
      end
      PH_ICHK: phase_d = (irq && int_en) ? PH_INT : PH_FADDR;
      PH_INT: begin
        ctl.int_take = 1'b1;
        phase_d      = PH_FADDR;
      end
      PH_HALT: phase_d = PH_HALT;
      default: phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FADDR;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R9: entry only from the check phase that follows an execute sequence
  a_r9_entry_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INT) |-> ($past(phase_q) == PH_ICHK));

  // R7: halt is sticky
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HALT) |=> (phase_q == PH_HALT));

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_core_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int HANDLER_ADDR = 'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] alu_y,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mbr,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              int_en,
  output logic              illegal
);

  localparam logic [ADDR_W-1:0] HANDLER = ADDR_W'(HANDLER_ADDR);

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d, shadow_q;
  logic [WORD_W-1:0] mbr_q, mbr_d, ir_q, acc_q;
  logic              ie_q, ill_q;
  logic              pc_en, mar_en, mbr_en, ie_en;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];

  always_comb begin
    pc_en = ctl.pc_inc | ctl.pc_jump | ctl.pc_reti | ctl.int_take;
    if (ctl.pc_jump)       pc_d = ir_addr;
    else if (ctl.pc_reti)  pc_d = shadow_q;
    else if (ctl.int_take) pc_d = HANDLER;
    else                   pc_d = pc_q + ADDR_W'(1);

    mar_en = ctl.mar_from_pc | ctl.mar_from_ir;
    mar_d  = ctl.mar_from_pc ? pc_q : ir_addr;

    mbr_en = ctl.mbr_from_mem | ctl.mbr_from_acc;
    mbr_d  = ctl.mbr_from_mem ? mem_rdata : acc_q;

    ie_en  = ctl.int_take | ctl.pc_reti;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      mar_q    <= '0;
      mbr_q    <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      shadow_q <= '0;
      ie_q     <= 1'b1;
      ill_q    <= 1'b0;
    end else begin
      if (pc_en)            pc_q     <= pc_d;
      if (mar_en)           mar_q    <= mar_d;
      if (mbr_en)           mbr_q    <= mbr_d;
      if (ctl.ir_load)      ir_q     <= mbr_q;
      if (ctl.acc_load)     acc_q    <= alu_y;
      if (ctl.int_take)     shadow_q <= pc_q;
      if (ie_en)            ie_q     <= ctl.pc_reti;
      if (ctl.flag_illegal) ill_q    <= 1'b1;
    end
  end

  assign pc      = pc_q;
  assign mar     = mar_q;
  assign mbr     = mbr_q;
  assign ir      = ir_q;
  assign acc     = acc_q;
  assign int_en  = ie_q;
  assign illegal = ill_q;

  // R11: return restores the value saved at entry and re-enables
  a_r11_reti_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_reti |=> (pc_q == $past(shadow_q)) && ie_q);

  // R9: entry lands on the handler with interrupts masked
  a_r9_entry_target: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.int_take |=> (pc_q == HANDLER) && !ie_q && (shadow_q == $past(pc_q)));

  // R10: no entry while masked
  a_r10_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.int_take |-> ie_q);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int OPC_W        = 4,
  parameter int HANDLER_ADDR = 'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic              illegal,
  output logic              int_en,
  output logic [WORD_W-1:0] acc_value,
  output logic [ADDR_W-1:0] pc_value
);

  localparam int OPC_LSB = WORD_W - OPC_W;

  logic              rst_meta_q, rst_sync_q;
  phase_e            phase;
  ctrl_t             ctl;
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mbr, ir, acc, alu_y;
  logic              ie;
  opcode_e           opcode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign opcode = opcode_e'(ir[WORD_W-1:OPC_LSB]);

  acc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .opcode (opcode),
    .irq    (irq),
    .int_en (ie),
    .phase  (phase),
    .ctl    (ctl)
  );

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .op      (ctl.alu_op),
    .acc_in  (acc),
    .opnd_in (mbr),
    .result  (alu_y)
  );

  acc_regs #(
    .WORD_W       (WORD_W),
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .ir        (ir),
    .acc       (acc),
    .int_en    (ie),
    .illegal   (illegal)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = ctl.mem_we;
  assign halted    = (phase == PH_HALT);
  assign int_en    = ie;
  assign acc_value = acc;
  assign pc_value  = pc;

  // R2: fetch advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (phase == PH_FIR) |=> (pc_value == $past(pc_value) + ADDR_W'(1)));

  // R3: the fetch address comes from the program counter
  a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (phase == PH_FADDR) |=> (mem_addr == $past(pc_value)));

  // R5: write data equals the accumulator
  a_r5_store_data: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_we |-> (mem_wdata == acc_value));

  // R7: a halted core writes nothing and holds its program counter
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    halted |=> !mem_we && $stable(pc_value));

  // R8: an illegal opcode always leaves the core halted
  a_r8_illegal_halts: assert property (@(posedge clk) disable iff (!rst_sync_q)
    illegal |-> halted);

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted, illegal, int_en;
  logic [15:0] acc_value;
  logic [11:0] pc_value;

  logic [15:0] mem [4096];
  int n_chk = 0;
  int n_fail = 0;
  int wr104 = 0;
  int wr_any = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  acc_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .illegal   (illegal),
    .int_en    (int_en),
    .acc_value (acc_value),
    .pc_value  (pc_value)
  );

  // synchronous memory model: read data one clock after the address
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_any <= wr_any + 1;
      if (mem_addr == 12'h104) wr104 <= wr104 + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  // {opcode, operand a, operand b, expected}
  localparam logic [51:0] VECS [7] = '{
    {4'h3, 16'h1234, 16'h1111, 16'h2345},  // add
    {4'h3, 16'hFFFF, 16'h0002, 16'h0001},  // add wraps
    {4'h4, 16'h0005, 16'h0007, 16'hFFFE},  // subtract wraps
    {4'h5, 16'hF0F0, 16'h3C3C, 16'h3030},  // and
    {4'h6, 16'hF0F0, 16'h0F01, 16'hFFF1},  // or
    {4'h7, 16'hA5A5, 16'h1357, 16'h5A5A},  // not, operand ignored
    {4'h1, 16'h1111, 16'hBEEF, 16'hBEEF}   // load
  };

  function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run_prog(string req, int limit);
    int cnt;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    while (!halted && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
    chk({req, " reached halt"}, {31'd0, halted}, 32'd1);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: state held in reset
    @(negedge clk);
    chk("R1 pc", {20'd0, pc_value}, 32'd0);
    chk("R1 acc", {16'd0, acc_value}, 32'd0);
    chk("R1 halted/illegal/int_en", {29'd0, halted, illegal, int_en}, 32'd1);

    // R2 R3 R4 R5 R7: ALU vector table
    for (int v = 0; v < 7; v++) begin
      logic [3:0]  op;
      logic [15:0] a, b, e;
      {op, a, b, e} = VECS[v];
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(op, 12'h101);
      mem[2] = ins(4'h2, 12'h102);
      mem[3] = ins(4'h0, 12'h000);
      mem[12'h100] = a;
      mem[12'h101] = b;
      run_prog("R4", 400);
      chk("R4 accumulator", {16'd0, acc_value}, {16'd0, e});
      chk("R5 stored word", {16'd0, mem[12'h102]}, {16'd0, e});
      chk("R7 pc after halt", {20'd0, pc_value}, 32'd4);
    end

    // R1: reset asserted mid-state clears at once
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {3'd0, acc_value, pc_value, halted}, 32'd0);

    // R6: jump skips the sequential path
    clear_mem();
    mem[0] = ins(4'h8, 12'h020);
    mem[1] = ins(4'h1, 12'h101);
    mem[2] = ins(4'h2, 12'h102);
    mem[3] = ins(4'h0, 12'h000);
    mem[12'h020] = ins(4'h1, 12'h100);
    mem[12'h021] = ins(4'h2, 12'h102);
    mem[12'h022] = ins(4'h0, 12'h000);
    mem[12'h100] = 16'h7777;
    mem[12'h101] = 16'h1111;
    run_prog("R6", 400);
    chk("R6 jump target used", {16'd0, mem[12'h102]}, 32'h7777);
    chk("R6 pc", {20'd0, pc_value}, 32'h023);

    // R8: undefined opcode
    clear_mem();
    mem[0] = ins(4'hB, 12'h100);
    run_prog("R8", 400);
    chk("R8 illegal flag", {31'd0, illegal}, 32'd1);
    chk("R8 pc", {20'd0, pc_value}, 32'd1);

    // R9 R10 R11: interrupt round trip with a held request
    clear_mem();
    mem[0] = ins(4'h1, 12'h100);
    mem[1] = ins(4'h3, 12'h101);
    mem[2] = ins(4'h2, 12'h102);
    mem[3] = ins(4'h0, 12'h000);
    mem[12'h010] = ins(4'h1, 12'h103);
    mem[12'h011] = ins(4'h2, 12'h104);
    mem[12'h012] = ins(4'h9, 12'h000);
    mem[12'h100] = 16'h0100;
    mem[12'h101] = 16'h0023;
    mem[12'h103] = 16'h4000;
    wr104 = 0;
    irq = 1'b1;
    fork
      run_prog("R9", 2000);
      begin
        wait (rst_n == 1'b1);
        wait (int_en == 1'b0);
        wait (wr104 != 0);
        @(negedge clk);
        irq = 1'b0;
      end
    join
    chk("R9 handler store", {16'd0, mem[12'h104]}, 32'h4000);
    chk("R10 single entry", wr104, 32'd1);
    chk("R11 resumed add", {16'd0, mem[12'h102]}, 32'h4023);
    chk("R11 int_en restored", {31'd0, int_en}, 32'd1);
    chk("R11 pc", {20'd0, pc_value}, 32'd4);

    // R7: a halted core ignores irq
    wr_any = 0;
    irq = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 still halted", {31'd0, halted}, 32'd1);
    chk("R7 pc held under irq", {20'd0, pc_value}, 32'd4);
    chk("R7 no writes", wr_any, 32'd0);
    irq = 1'b0;

    summary();
  end

endmodule